// File: doc/BRIEF.md
# Multicore Boot Release Table

This block is a small memory-mapped table that lets the primary processor core of a multicore chip start its secondary cores. Each secondary core owns one 32-byte record in a 1024-byte window. Every record holds a 64-bit start address, a 64-bit first-argument value, a 32-bit processor ID and two reserved areas. After reset every record is parked: bit 0 of its start address is set.

Software starts a core by writing its record. After each accepted write, the block looks at bit 0 of that record's start address. When the bit is clear, it sends a one-cycle release pulse to that core. Together with the pulse it presents the boot parameters. The start address is split into a 64 MiB-aligned mapping base and an offset inside that window, and the offset is used as the start program counter. The stored argument is presented as the first argument. In the same step the record's processor ID is replaced with the ID the core reports.

The bus side takes 1-, 2- and 4-byte accesses with big-endian byte order. Record 0 belongs to the primary core, which never waits in the table, so it cannot be written.

Top module: `boot_release_table`

## Requirements
- R1: After reset, record i reads back start address 1, argument i and processor ID i, and all of its reserved bytes read 0.
- R2: Record i occupies byte addresses 32*i to 32*i+31. Within a record, the start address is at bytes 0..7, the argument at bytes 8..15, a reserved word at 16..19, the processor ID at 20..23 and reserved bytes at 24..31. Every field is big-endian: the lowest address holds the most significant byte. A 1- or 2-byte read returns its value right-aligned and zero-extended in the 32-bit read data.
- R3: busSize gives the access length in bytes (1, 2 or 4). A write changes only the bytes it addresses. Address bits below the access size are ignored, so every access is aligned to its own size.
- R4: Writes to record 0, and to any record whose index is at or above NUM_CORES, change nothing and release nothing. Those records remain readable.
- R5: A write whose busSize is not 1, 2 or 4 changes nothing and releases nothing.
- R6: Each read is answered with busRvalid in the cycle after the request. A read whose busSize is not 1, 2 or 4 answers with busErr high and zero data.
- R7: After every accepted write, if bit 0 of that record's start address is 0, then bit i of releaseVec pulses high for exactly one cycle, in the second cycle after the write request. This also holds for a write to any other field of an already released record. If bit 0 is 1, no pulse follows.
- R8: When a release pulses, bootPc equals the start address with every bit at or above bit 26 cleared. mapBase equals the start address with its low 26 bits cleared, and bootArg equals the stored argument. These outputs hold until the next release. mapSize is always 64 MiB (0x4000000).
- R9: When record i is released, its processor ID field is overwritten with corePir[32*i+31:32*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte address inside the table |
| busSize | input | 3 | Access length in bytes |
| busWdata | input | 32 | Write data, right-aligned |
| busRvalid | output | 1 | Read response valid |
| busRdata | output | 32 | Read data, right-aligned |
| busErr | output | 1 | Read response error |
| corePir | input | 1024 | Processor ID reported by each core, 32 bits per core |
| releaseVec | output | 32 | One-cycle release pulse, one bit per core |
| bootPc | output | 64 | Start program counter of the last released core |
| mapBase | output | 64 | Mapping window base of the last released core |
| bootArg | output | 64 | First argument of the last released core |
| mapSize | output | 64 | Mapping window size |

## Verification
Suppose a stored record is corrupted, for example a bad byte lane or a wrong record index. Nothing shows until that record is read back or released, and then it shows within two cycles. It appears either as a wrong read word or as a release pulse on the wrong bit, at the wrong time, or missing. A wrong split of the start address appears on bootPc and mapBase in the same cycle as the pulse. A missed processor ID update appears only on a later read of that field. For this reason the bench reads the ID back after every release.

// File: rtl/bootrel_pkg.sv
package bootrel_pkg;
  localparam int RECORD_BYTES = 32;
  localparam int WORDS_PER_RECORD = 8;
  localparam int PIR_WORD = 5;

  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    logic [3:0] byteEn;
    logic       pidLoad;
  } bootStrobe_t;
endpackage

// File: rtl/bootrel_ctrl.sv
module bootrel_ctrl
  import bootrel_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_CORES   = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [IDX_W-1:0]       entryIdx,
  input  logic [1:0]             byteOff,
  input  logic [2:0]             busSize,
  input  logic                   startLsb,
  output bootStrobe_t            strobe,
  output logic [IDX_W-1:0]       pendIdx,
  output logic                   busRvalid,
  output logic                   busErr,
  output logic [NUM_ENTRIES-1:0] releaseVec
);
  logic sizeOk;
  logic entryWritable;
  logic pendValid;
  logic fire;

  assign sizeOk = (busSize == 3'd1) || (busSize == 3'd2) || (busSize == 3'd4);
  assign entryWritable = (entryIdx != '0) && (32'(entryIdx) < NUM_CORES);
  assign fire = pendValid && !startLsb;

  always_comb begin
    strobe.wrEn    = busValid && busWrite && sizeOk && entryWritable;
    strobe.rdEn    = busValid && !busWrite && sizeOk;
    strobe.pidLoad = fire;
    case (busSize)
      3'd1:    strobe.byteEn = 4'b1000 >> byteOff;
      3'd2:    strobe.byteEn = byteOff[1] ? 4'b0011 : 4'b1100;
      3'd4:    strobe.byteEn = 4'b1111;
      default: strobe.byteEn = 4'b0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid  <= 1'b0;
      pendIdx    <= '0;
      busRvalid  <= 1'b0;
      busErr     <= 1'b0;
      releaseVec <= '0;
    end else begin
      pendValid  <= strobe.wrEn;
      pendIdx    <= entryIdx;
      busRvalid  <= busValid && !busWrite;
      busErr     <= busValid && !busWrite && !sizeOk;
      releaseVec <= fire ? (NUM_ENTRIES'(1) << pendIdx) : '0;
    end
  end

  p_release_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(releaseVec));
  p_release_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |-> ##2 ($past(startLsb) || $countones(releaseVec) == 1));
  p_no_release_entry0_r4: assert property (@(posedge clk) disable iff (rst)
    !releaseVec[0]);
  p_err_is_response_r6: assert property (@(posedge clk) disable iff (rst)
    busErr |-> busRvalid);
endmodule

// File: rtl/bootrel_data.sv
module bootrel_data
  import bootrel_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int MAP_BITS    = 26,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int WORD_W     = IDX_W + 3,
  localparam int ADDR_W     = WORD_W + 2,
  localparam int NUM_WORDS  = NUM_ENTRIES * WORDS_PER_RECORD
) (
  input  logic                      clk,
  input  logic                      rst,
  input  bootStrobe_t               strobe,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [2:0]                busSize,
  input  logic [31:0]               busWdata,
  input  logic [IDX_W-1:0]          pendIdx,
  input  logic [NUM_ENTRIES*32-1:0] corePir,
  output logic                      startLsb,
  output logic [31:0]               busRdata,
  output logic [63:0]               bootPc,
  output logic [63:0]               mapBase,
  output logic [63:0]               bootArg
);
  localparam logic [63:0] OFFSET_MASK = (64'(1) << MAP_BITS) - 64'(1);

  logic [31:0] mem [NUM_WORDS];
  logic [WORD_W-1:0] wordSel;
  logic [31:0] wrLanes;
  logic [31:0] rdWord;
  logic [31:0] rdVal;
  logic [63:0] startAddr;
  logic [63:0] argVal;

  assign wordSel = busAddr[ADDR_W-1:2];
  assign rdWord  = mem[wordSel];
  assign startAddr = {mem[{pendIdx, 3'd0}], mem[{pendIdx, 3'd1}]};
  assign argVal    = {mem[{pendIdx, 3'd2}], mem[{pendIdx, 3'd3}]};
  assign startLsb  = startAddr[0];

  always_comb begin
    case (busSize)
      3'd1:    wrLanes = {4{busWdata[7:0]}};
      3'd2:    wrLanes = {2{busWdata[15:0]}};
      default: wrLanes = busWdata;
    endcase
    case (busSize)
      3'd1:    rdVal = {24'd0, 8'(rdWord >> (8 * (3 - busAddr[1:0])))};
      3'd2:    rdVal = {16'd0, busAddr[1] ? rdWord[15:0] : rdWord[31:16]};
      default: rdVal = rdWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        for (int w = 0; w < WORDS_PER_RECORD; w++) begin
          case (w)
            1:       mem[e*WORDS_PER_RECORD + w] <= 32'd1;
            3, 5:    mem[e*WORDS_PER_RECORD + w] <= 32'(e);
            default: mem[e*WORDS_PER_RECORD + w] <= 32'd0;
          endcase
        end
      end
      busRdata <= '0;
      bootPc   <= '0;
      mapBase  <= '0;
      bootArg  <= '0;
    end else begin
      if (strobe.wrEn) begin
        for (int b = 0; b < 4; b++) begin
          if (strobe.byteEn[b]) mem[wordSel][8*b +: 8] <= wrLanes[8*b +: 8];
        end
      end
      if (strobe.pidLoad) begin
        mem[{pendIdx, 3'(PIR_WORD)}] <= corePir[32*pendIdx +: 32];
        bootPc  <= startAddr & OFFSET_MASK;
        mapBase <= startAddr & ~OFFSET_MASK;
        bootArg <= argVal;
      end
      busRdata <= strobe.rdEn ? rdVal : '0;
    end
  end

  p_split_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.pidLoad |=> ((bootPc | mapBase) == $past(startAddr)));
  p_entry0_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(mem[1]) && $stable(mem[5])));
endmodule

// File: rtl/boot_release_table.sv
module boot_release_table
  import bootrel_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_CORES   = 4,
  parameter int MAP_BITS    = 26,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int ADDR_W     = $clog2(NUM_ENTRIES * RECORD_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      busValid,
  input  logic                      busWrite,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [2:0]                busSize,
  input  logic [31:0]               busWdata,
  output logic                      busRvalid,
  output logic [31:0]               busRdata,
  output logic                      busErr,
  input  logic [NUM_ENTRIES*32-1:0] corePir,
  output logic [NUM_ENTRIES-1:0]    releaseVec,
  output logic [63:0]               bootPc,
  output logic [63:0]               mapBase,
  output logic [63:0]               bootArg,
  output logic [63:0]               mapSize
);
  bootStrobe_t strobe;
  logic [IDX_W-1:0] pendIdx;
  logic startLsb;

  assign mapSize = 64'(1) << MAP_BITS;

  bootrel_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CORES(NUM_CORES)) u_ctrl (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .entryIdx(busAddr[ADDR_W-1:5]), .byteOff(busAddr[1:0]), .busSize(busSize),
    .startLsb(startLsb), .strobe(strobe), .pendIdx(pendIdx),
    .busRvalid(busRvalid), .busErr(busErr), .releaseVec(releaseVec)
  );

  bootrel_data #(.NUM_ENTRIES(NUM_ENTRIES), .MAP_BITS(MAP_BITS)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .pendIdx(pendIdx), .corePir(corePir),
    .startLsb(startLsb), .busRdata(busRdata), .bootPc(bootPc),
    .mapBase(mapBase), .bootArg(bootArg)
  );

  p_err_zero_data_r6: assert property (@(posedge clk) disable iff (rst)
    busErr |-> (busRdata == '0));
endmodule

// File: tb/test_boot_release_table.sv
module test_boot_release_table;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busValid = 1'b0;
  logic busWrite = 1'b0;
  logic [9:0] busAddr = '0;
  logic [2:0] busSize = 3'd4;
  logic [31:0] busWdata = '0;
  logic busRvalid, busErr;
  logic [31:0] busRdata;
  logic [1023:0] corePir;
  logic [31:0] releaseVec;
  logic [63:0] bootPc, mapBase, bootArg, mapSize;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [32:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  boot_release_table i_boot_release_table (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRvalid(busRvalid), .busRdata(busRdata), .busErr(busErr),
    .corePir(corePir), .releaseVec(releaseVec), .bootPc(bootPc),
    .mapBase(mapBase), .bootArg(bootArg), .mapSize(mapSize)
  );

  always_comb begin
    for (int i = 0; i < 32; i++) corePir[32*i +: 32] = 32'h100 + 32'(i);
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && busRvalid) begin
      if (expQ.size() == 0) begin
        chk("R6 unexpected response", 64'(busRvalid), 64'd0);
      end else begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {31'd0, busErr, busRdata}, {31'd0, e});
      end
    end
  end

  task automatic busRd(int rec, int off, int size, logic [31:0] expData, bit expErr, string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0;
    busAddr = 10'(rec * 32 + off); busSize = 3'(size);
    expQ.push_back({expErr, expData});
    tagQ.push_back(tag);
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic busWr(int rec, int off, int size, logic [31:0] data, int expRel, string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1;
    busAddr = 10'(rec * 32 + off); busSize = 3'(size); busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    @(negedge clk);
    chk({tag, " R7 pulse"}, 64'(releaseVec), expRel < 0 ? 64'd0 : (64'd1 << expRel));
    if (expRel >= 0) begin
      @(negedge clk);
      chk("R7 single cycle", 64'(releaseVec), 64'd0);
    end
  endtask

  task automatic chkOut(logic [63:0] pc, logic [63:0] base, logic [63:0] arg);
    chk("R8 bootPc", bootPc, pc);
    chk("R8 mapBase", mapBase, base);
    chk("R8 bootArg", bootArg, arg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 releaseVec reset", 64'(releaseVec), 64'd0);
    chk("R1 bootPc reset", bootPc, 64'd0);
    chk("R8 mapSize", mapSize, 64'h400_0000);
    // R1 reset contents
    busRd(0, 0, 4, 32'd0, 0, "R1 rec0 addr hi");
    busRd(0, 4, 4, 32'd1, 0, "R1 rec0 addr lo");
    busRd(0, 20, 4, 32'd0, 0, "R1 rec0 pid");
    busRd(7, 4, 4, 32'd1, 0, "R1 rec7 addr lo");
    busRd(7, 12, 4, 32'd7, 0, "R1 rec7 arg");
    busRd(7, 20, 4, 32'd7, 0, "R1 rec7 pid");
    busRd(7, 16, 4, 32'd0, 0, "R1 rec7 resv");
    busRd(7, 28, 4, 32'd0, 0, "R1 rec7 tail");
    // R2 sub-word big-endian reads
    busRd(5, 23, 1, 32'd5, 0, "R2 byte lsb");
    busRd(5, 20, 1, 32'd0, 0, "R2 byte msb");
    busRd(5, 22, 2, 32'd5, 0, "R2 half low");
    busRd(5, 20, 2, 32'd0, 0, "R2 half high");
    busRd(5, 7, 1, 32'd1, 0, "R2 addr byte");
    // R6 bad read sizes
    busRd(5, 20, 3, 32'd0, 1, "R6 size3");
    busRd(5, 20, 0, 32'd0, 1, "R6 size0");
    // R7 R8 R9 word write release
    busWr(2, 4, 4, 32'h0A40_0100, 2, "R7 rec2");
    chkOut(64'h0240_0100, 64'h0800_0000, 64'd2);
    busRd(2, 20, 4, 32'h102, 0, "R9 rec2 pid");
    busRd(2, 4, 4, 32'h0A40_0100, 0, "R3 rec2 addr");
    // R7 no release while bit0 set
    busWr(1, 0, 4, 32'd1, -1, "R7 rec1 hi");
    busWr(1, 12, 4, 32'hDEAD, -1, "R7 rec1 arg");
    busRd(1, 12, 4, 32'hDEAD, 0, "R3 rec1 arg");
    busRd(1, 0, 4, 32'd1, 0, "R3 rec1 hi");
    busWr(1, 6, 2, 32'd0, 1, "R7 rec1 half");
    chkOut(64'd0, 64'h1_0000_0000, 64'hDEAD);
    busWr(1, 16, 4, 32'h55, 1, "R7 rec1 rewrite");
    busRd(1, 20, 4, 32'h101, 0, "R9 rec1 pid");
    busRd(1, 16, 4, 32'h55, 0, "R3 rec1 resv");
    // R3 byte and halfword lanes
    busWr(3, 7, 1, 32'h0, 3, "R3 rec3 byte");
    chkOut(64'd0, 64'd0, 64'd3);
    busWr(3, 14, 1, 32'hAB, 3, "R3 rec3 byte2");
    busRd(3, 12, 4, 32'h0000_AB03, 0, "R3 byte lane");
    busWr(3, 9, 2, 32'hBEEF, 3, "R3 misaligned half");
    busRd(3, 8, 4, 32'hBEEF_0000, 0, "R3 half aligned");
    chkOut(64'd0, 64'd0, 64'hBEEF_0000_0000_AB03);
    // R4 protected records
    busWr(0, 4, 4, 32'd0, -1, "R4 rec0");
    busRd(0, 4, 4, 32'd1, 0, "R4 rec0 kept");
    busWr(4, 4, 4, 32'd0, -1, "R4 rec4");
    busRd(4, 4, 4, 32'd1, 0, "R4 rec4 kept");
    busRd(4, 20, 4, 32'd4, 0, "R4 rec4 pid");
    busWr(31, 4, 4, 32'd0, -1, "R4 rec31");
    busRd(31, 4, 4, 32'd1, 0, "R4 rec31 kept");
    // R5 bad write sizes
    busWr(2, 12, 3, 32'hFFFF, -1, "R5 size3");
    busWr(2, 12, 0, 32'hFFFF, -1, "R5 size0");
    busRd(2, 12, 4, 32'd2, 0, "R5 rec2 arg kept");
    repeat (3) @(negedge clk);
    chk("R6 all responses", 64'(expQ.size()), 64'd0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule